// File: doc/BRIEF.md
# Triple-Copy Memory with Background Refresh

This block is a word-addressed memory held in three identical dual-port RAM copies. A user write goes into all three copies at once. A user read returns, one clock later, the bitwise majority of the three stored words. A bit upset in one copy is therefore hidden from the reader. Upsets inside such memories are not repaired by reloading the device configuration, so the block repairs its own contents.

The second port of every copy belongs to a small refresh engine. While `scrub_en` is high, a pointer walks every address in ascending order and wraps back to zero. At each address it reads all three copies, votes them, and writes the voted word back into all three. This takes two cycles per address. A single-copy upset is therefore cleared within one full pass, even at an address the user never reads. This stops a second upset from later joining the first and outvoting the good copy.

The engine is a three-state machine:
- `SC_IDLE` moves to `SC_READ` when `scrub_en` is high.
- `SC_READ` always moves to `SC_WRITE`.
- `SC_WRITE` moves to `SC_READ` when `scrub_en` is still high, and to `SC_IDLE` otherwise.

A user write to the address being refreshed always wins, and the write-back for that address is dropped. Two counters report the repairs made and the passes completed.

Top module: `tri_store`

## Requirements
- R1: A user write (`u_en`=1, `u_we`=1) stores `u_wdata` at `u_addr` in all three copies. Rewriting a word therefore restores it even when two copies held a wrong value.
- R2: A user read (`u_en`=1, `u_we`=0) presents the bitwise majority of the three copies on `u_rdata` from the clock edge after the request. A word differs from the written value in only one copy per bit position still reads as the written value, even when different copies hold the faulty bits.
- R3: When two copies agree on a wrong bit value, the read returns that value, because the vote is taken per bit.
- R4: The refresh pointer starts at 0, moves up by one address per refreshed word and wraps from DEPTH-1 to 0. `sweep_count` goes up by one at each wrap.
- R5: A user write that lands in the same cycle as the write-back of the same address wins, and that write-back is dropped. A user write to that address during its `SC_READ` cycle also wins, and that write-back is dropped.
- R6: `fix_count` goes up by exactly one for each performed write-back where any copy differed from the voted word. It changes at no other time.
- R7: Each address takes exactly one `SC_READ` cycle followed by one `SC_WRITE` cycle, so with `scrub_en` held high a full pass takes 2*DEPTH cycles.
- R8: When `scrub_en` falls, the address in progress is completed and the engine then waits in `SC_IDLE` with the pointer held. When `scrub_en` rises again, the engine resumes from that pointer.
- R9: Reset (`rst_n`=0) clears both counters, the pointer and the state machine, and leaves the stored words unchanged.
- R10: After one full pass, a single-copy upset at an address never read by the user has been rewritten with the voted word in all three copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| u_en | input | 1 | User access request |
| u_we | input | 1 | 1 = write, 0 = read, when `u_en` is high |
| u_addr | input | AW | User word address (AW = clog2(DEPTH)) |
| u_wdata | input | WIDTH | User write data |
| u_rdata | output | WIDTH | Voted read data, valid the cycle after a read |
| scrub_en | input | 1 | Lets the refresh engine run |
| fix_count | output | CNT_W | Number of refreshed words that had a disagreeing copy |
| sweep_count | output | CNT_W | Number of completed refresh passes |

## Verification
The assertions assume that `u_addr` is always below DEPTH and that `scrub_en` and the user signals change only between clock edges. The bench drives every input on the falling edge and uses only addresses inside the memory. The assertions also assume that copies are disturbed only from outside the user path. The bench models upsets by overwriting a single stored word of one copy between edges, and only while no user write is in flight.

// File: rtl/tri_store_pkg.sv
package tri_store_pkg;
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_READ  = 2'd1,
        SC_WRITE = 2'd2
    } scrub_state_e;
endpackage

// File: rtl/tri_bank.sv
module tri_bank #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             a_en,
    input  logic             a_we,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_en,
    input  logic             b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Port B is handled after port A; the scrubber never writes the
    // address the user writes in the same cycle.
    always_ff @(posedge clk) begin
        if (a_en) begin
            if (a_we) mem[a_addr] <= a_wdata;
            else      a_rdata     <= mem[a_addr];
        end
        if (b_en) begin
            if (b_we) mem[b_addr] <= b_wdata;
            else      b_rdata     <= mem[b_addr];
        end
    end
endmodule

// File: rtl/tri_vote.sv
module tri_vote #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x0,
    input  logic [WIDTH-1:0] x1,
    input  logic [WIDTH-1:0] x2,
    output logic [WIDTH-1:0] maj
);
    always_comb maj = (x0 & x1) | (x0 & x2) | (x1 & x2);
endmodule

// File: rtl/tri_scrub.sv
module tri_scrub
    import tri_store_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scrub_en,
    input  logic             u_wr,
    input  logic [AW-1:0]    u_addr,
    input  logic [WIDTH-1:0] c0,
    input  logic [WIDTH-1:0] c1,
    input  logic [WIDTH-1:0] c2,
    input  logic [WIDTH-1:0] voted,
    output scrub_state_e     state,
    output logic [AW-1:0]    ptr,
    output logic             b_en,
    output logic             b_we,
    output logic [CNT_W-1:0] fix_count,
    output logic [CNT_W-1:0] sweep_count
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    scrub_state_e nxt;
    logic         hit_q;
    logic         blocked;
    logic         differs;
    logic         at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SC_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        blocked = hit_q || (u_wr && (u_addr == ptr));
        differs = |((c0 ^ voted) | (c1 ^ voted) | (c2 ^ voted));
        at_last = (ptr == LAST);
        b_en    = 1'b0;
        b_we    = 1'b0;
        unique case (state)
            SC_IDLE: begin
                if (scrub_en) nxt = SC_READ;
            end
            SC_READ: begin
                b_en = 1'b1;
                nxt  = SC_WRITE;
            end
            SC_WRITE: begin
                b_en = !blocked;
                b_we = !blocked;
                nxt  = scrub_en ? SC_READ : SC_IDLE;
            end
            default: nxt = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr         <= '0;
            hit_q       <= 1'b0;
            fix_count   <= '0;
            sweep_count <= '0;
        end else begin
            hit_q <= (state == SC_READ) && u_wr && (u_addr == ptr);
            if (state == SC_WRITE) begin
                ptr <= at_last ? '0 : ptr + 1'b1;
                if (at_last) sweep_count <= sweep_count + 1'b1;
                if (!blocked && differs) fix_count <= fix_count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tri_store.sv
module tri_store
    import tri_store_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int WIDTH = 32,
    parameter int CNT_W = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             u_en,
    input  logic             u_we,
    input  logic [AW-1:0]    u_addr,
    input  logic [WIDTH-1:0] u_wdata,
    output logic [WIDTH-1:0] u_rdata,
    input  logic             scrub_en,
    output logic [CNT_W-1:0] fix_count,
    output logic [CNT_W-1:0] sweep_count
);
    localparam int COPIES = 3;

    logic [WIDTH-1:0] a_rd [COPIES];
    logic [WIDTH-1:0] b_rd [COPIES];
    logic [WIDTH-1:0] scrub_word;
    logic [AW-1:0]    scrub_ptr;
    logic             scrub_en_b;
    logic             scrub_we;
    logic             u_wr;
    scrub_state_e     scrub_state;

    assign u_wr = u_en && u_we;

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        tri_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_bank (
            .clk     (clk),
            .a_en    (u_en),
            .a_we    (u_we),
            .a_addr  (u_addr),
            .a_wdata (u_wdata),
            .a_rdata (a_rd[g]),
            .b_en    (scrub_en_b),
            .b_we    (scrub_we),
            .b_addr  (scrub_ptr),
            .b_wdata (scrub_word),
            .b_rdata (b_rd[g])
        );
    end

    tri_vote #(.WIDTH(WIDTH)) u_vote_user (
        .x0 (a_rd[0]), .x1 (a_rd[1]), .x2 (a_rd[2]), .maj (u_rdata)
    );

    tri_vote #(.WIDTH(WIDTH)) u_vote_scrub (
        .x0 (b_rd[0]), .x1 (b_rd[1]), .x2 (b_rd[2]), .maj (scrub_word)
    );

    tri_scrub #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_scrub (
        .clk         (clk),
        .rst_n       (rst_n),
        .scrub_en    (scrub_en),
        .u_wr        (u_wr),
        .u_addr      (u_addr),
        .c0          (b_rd[0]),
        .c1          (b_rd[1]),
        .c2          (b_rd[2]),
        .voted       (scrub_word),
        .state       (scrub_state),
        .ptr         (scrub_ptr),
        .b_en        (scrub_en_b),
        .b_we        (scrub_we),
        .fix_count   (fix_count),
        .sweep_count (sweep_count)
    );
endmodule

// File: rtl/tri_store_chk.sv
module tri_store_chk
    import tri_store_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input scrub_state_e     state,
    input logic [AW-1:0]    ptr,
    input logic             b_we,
    input logic             u_wr,
    input logic [AW-1:0]    u_addr,
    input logic [CNT_W-1:0] fix_count
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    p_user_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && u_wr) |-> (ptr != u_addr));

    p_read_then_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_READ) |=> (state == SC_WRITE));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_WRITE && ptr == LAST) |=> (ptr == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_WRITE && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SC_WRITE) |=> $stable(ptr));

    p_fix_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SC_WRITE) |=> $stable(fix_count));

    p_fix_by_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_count != $past(fix_count)) |-> (fix_count == $past(fix_count) + 1'b1));
endmodule

bind tri_store tri_store_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (scrub_state),
    .ptr       (scrub_ptr),
    .b_we      (scrub_we),
    .u_wr      (u_wr),
    .u_addr    (u_addr),
    .fix_count (fix_count)
);

// File: tb/sim_tri_store.sv
module sim_tri_store;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int CNT_W = 8;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             u_en = 1'b0;
    logic             u_we = 1'b0;
    logic [AW-1:0]    u_addr = '0;
    logic [WIDTH-1:0] u_wdata = '0;
    logic [WIDTH-1:0] u_rdata;
    logic             scrub_en = 1'b0;
    logic [CNT_W-1:0] fix_count;
    logic [CNT_W-1:0] sweep_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tri_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u0 (
        .clk, .rst_n, .u_en, .u_we, .u_addr, .u_wdata, .u_rdata,
        .scrub_en, .fix_count, .sweep_count
    );

    function automatic logic [WIDTH-1:0] pat(input int a);
        return WIDTH'(a * 7 + 3);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks are entered and left on a falling edge
    task automatic uwrite(input int a, input logic [WIDTH-1:0] d);
        u_en = 1'b1; u_we = 1'b1; u_addr = AW'(a); u_wdata = d;
        @(negedge clk);
        u_en = 1'b0; u_we = 1'b0;
    endtask

    task automatic uread(input int a, output logic [WIDTH-1:0] d);
        u_en = 1'b1; u_we = 1'b0; u_addr = AW'(a);
        @(negedge clk);
        u_en = 1'b0;
        d = u_rdata;
    endtask

    task automatic upset(input int copy, input int a, input logic [WIDTH-1:0] d);
        case (copy)
            0: u0.g_copy[0].u_bank.mem[a] = d;
            1: u0.g_copy[1].u_bank.mem[a] = d;
            default: u0.g_copy[2].u_bank.mem[a] = d;
        endcase
    endtask

    task automatic wait_sweep(input int target, output int cyc);
        cyc = 0;
        while (int'(sweep_count) != target && cyc < 4 * DEPTH + 8) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset_state();
        check("R9 fix_count after reset", int'(fix_count), 0);
        check("R9 sweep_count after reset", int'(sweep_count), 0);
    endtask

    task automatic t_fill_and_read();
        logic [WIDTH-1:0] d;
        for (int a = 0; a < DEPTH; a++) uwrite(a, pat(a));
        uread(0, d);          check("R2 read addr 0", int'(d), int'(pat(0)));
        uread(DEPTH - 1, d);  check("R2 read last addr", int'(d), int'(pat(DEPTH - 1)));
        uread(7, d);          check("R2 read addr 7", int'(d), int'(pat(7)));
    endtask

    task automatic t_vote();
        logic [WIDTH-1:0] d;
        upset(1, 3, ~pat(3));
        uread(3, d); check("R2 one copy inverted", int'(d), int'(pat(3)));
        upset(0, 4, pat(4) ^ 8'h0F);
        upset(2, 4, pat(4) ^ 8'hF0);
        uread(4, d); check("R2 faults spread over copies", int'(d), int'(pat(4)));
        upset(0, 6, 8'hA5);
        upset(1, 6, 8'hA5);
        uread(6, d); check("R3 two copies agree", int'(d), 32'hA5);
        uwrite(6, pat(6));
        uread(6, d); check("R1 rewrite fixes all copies", int'(d), int'(pat(6)));
    endtask

    task automatic t_sweep();
        int cyc;
        upset(2, 9, 8'h3C);
        scrub_en = 1'b1;
        wait_sweep(1, cyc);
        check("R4 first pass wraps", int'(sweep_count), 1);
        wait_sweep(2, cyc);
        check("R7 pass length in cycles", cyc, 2 * DEPTH);
        check("R6 three repairs counted", int'(fix_count), 3);
        scrub_en = 1'b0;
    endtask

    task automatic t_pause_and_repair();
        logic [WIDTH-1:0] d;
        int cyc;
        logic [CNT_W-1:0] s0;
        repeat (2) @(negedge clk);
        s0 = sweep_count;
        repeat (4 * DEPTH) @(negedge clk);
        check("R8 paused sweep holds", int'(sweep_count), int'(s0));
        upset(0, 9, 8'h3C);
        uread(9, d); check("R10 unread word was refreshed", int'(d), int'(pat(9)));
        upset(0, 3, ~pat(3));
        uread(3, d); check("R10 copy 1 of addr 3 refreshed", int'(d), int'(pat(3)));
        scrub_en = 1'b1;
        wait_sweep(3, cyc);
        check("R8 resumed pass completes", int'(sweep_count), 3);
        check("R6 repairs after resume", int'(fix_count), 5);
    endtask

    task automatic t_collision();
        logic [WIDTH-1:0] d;
        int bad = 0;
        for (int i = 0; i < 4 * DEPTH; i++) begin
            uwrite(12, WIDTH'(i + 100));
            @(negedge clk);
            uread(12, d);
            if (d != WIDTH'(i + 100)) begin
                if (bad == 0)
                    check("R5 user write kept", int'(d), int'(WIDTH'(i + 100)));
                bad++;
            end
        end
        check("R5 lost user writes", bad, 0);
        scrub_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_keeps_data();
        logic [WIDTH-1:0] d;
        uwrite(2, 8'h5A);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R9 fix_count cleared", int'(fix_count), 0);
        check("R9 sweep_count cleared", int'(sweep_count), 0);
        uread(2, d); check("R9 data survives reset", int'(d), 32'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_fill_and_read();
        t_vote();
        t_sweep();
        t_pause_and_repair();
        t_collision();
        t_reset_keeps_data();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule